// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a frame clock and a data line. It runs entirely in a faster system clock domain. The three serial inputs pass through synchronizers, and the active bit-clock edge is found by comparing successive synchronized levels. The data line and the frame clock are sampled at each active edge.

Static configuration inputs set four things:
- the framing format: I2S, left-justified, or a DSP mode with a one-bit-wide sync pulse;
- the word length: 16, 20, 24 or 32 bits;
- which bit-clock edge samples the data;
- in DSP mode, whether the first data bit follows the sync pulse at once or one bit later.

Each completed frame delivers one left word and one right word. Each word is aligned to the top of a 32-bit field, and the unused low bits are zero. A single-cycle strobe marks the frame. The configuration is expected to be changed only while the block is held in reset.

Top module: `srx_top`

## Requirements
- R1: With `fmt_i` = 0 (I2S), the channel is the one whose frame-clock level is low for left and high for right. The MSB is taken on the second active bit-clock edge after a frame-clock change.
- R2: With `fmt_i` = 1 (left-justified), a high frame clock carries left and a low frame clock carries right. The MSB is taken on the first active edge after a frame-clock change.
- R3: With `fmt_i` = 2 or 3 (DSP), the frame clock is a pulse one bit period wide. The left word starts on the first active edge after the edge that sees the pulse, and the right word follows it with no gap, provided `dsp_late_i` = 0.
- R4: With DSP format and `dsp_late_i` = 1, every word position moves one active edge later, so the left MSB lands on the second edge after the pulse.
- R5: Each word arrives MSB first. Its length comes from `wlen_i`: 0 selects 24 bits (the value held at reset), 1 selects 16, 2 selects 20, and 3 selects 32.
- R6: On `left_o` and `right_o`, a word of N bits sits in bits 31 down to 32-N, and all lower bits are zero.
- R7: With `fall_edge_i` = 0, data and frame clock are sampled on bit-clock rising edges. With `fall_edge_i` = 1, they are sampled on falling edges.
- R8: Bit-clock cycles after a word's LSB and before the next frame boundary do not alter any output. This also holds when the bit clock stays idle during those cycles.
- R9: `valid_o` is high for exactly one system clock per frame, once both the left and the right word of that frame are captured. `left_o` and `right_o` change only in that cycle.
- R10: While `rst_ni` is low, `left_o`, `right_o` and `valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock (a level in I2S and left-justified formats, a pulse in DSP format) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing format: 0 = I2S, 1 = left-justified, 2 or 3 = DSP |
| wlen_i | input | 2 | Word length code: 0 = 24, 1 = 16, 2 = 20, 3 = 32 |
| fall_edge_i | input | 1 | 1 = sample on falling bit-clock edges |
| dsp_late_i | input | 1 | DSP only: 1 = data starts one bit later |
| left_o | output | 32 | Left sample, aligned to the top of the field |
| right_o | output | 32 | Right sample, aligned to the top of the field |
| valid_o | output | 1 | One-cycle strobe when a frame is complete |

## Verification
Random words are sent in every format with word lengths that either fill the half-frame or leave spare slots. The I2S case where a 32-bit word fills its half exactly puts the right LSB on the edge that already sees the next frame-clock level, so it exposes a framing point that is one edge off. Back-to-back DSP frames in both delay settings separate an early MSB from a late one, and runs on falling edges separate the two sampling polarities. In the spare slots the data line carries junk, and in some runs the bit clock is gated off there. Any capture past the LSB would therefore show up as a corrupted word or as an extra strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_DSP = 2'd2
  } srx_fmt_e;

  // code 0 is the reset-time default of 24 bits
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 16;
      2'd2:    return 20;
      2'd3:    return 32;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  output logic ev_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign ev_o = fall_i ? (prev_q & ~lvl_i) : (~prev_q & lvl_i);

endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int POS_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic              fclk_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              late_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [2:0]        hist_q;
  logic [POS_W-1:0]  pos_q, pos_d, idx, n;
  logic              locked_q, lock_d, got_left_q;
  logic [WORD_W-1:0] sh_q, word_d, lbuf_q, zmask;
  logic [IDX_W-1:0]  bit_sel;
  logic              is_dsp, is_lj, f, fp, bound, second, rchan, cap, last;

  assign is_dsp = fmt_i[1];
  assign is_lj  = (fmt_i == FMT_LJ);
  assign n      = POS_W'(word_bits(wlen_i));
  assign zmask  = {WORD_W{1'b1}} >> n;

  // Pick the framing view: I2S and early DSP see the frame clock one edge late,
  // late DSP two edges late, so every format reduces to "MSB on the boundary edge".
  always_comb begin
    f  = hist_q[0];
    fp = hist_q[1];
    if (!is_dsp && is_lj) begin
      f  = fclk_i;
      fp = hist_q[0];
    end else if (is_dsp && late_i) begin
      f  = hist_q[1];
      fp = hist_q[2];
    end
  end

  always_comb begin
    bound   = is_dsp ? (f & ~fp) : (f ^ fp);
    pos_d   = bound ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + 1'b1);
    second  = is_dsp & (pos_d >= n);
    idx     = second ? pos_d - n : pos_d;
    rchan   = is_dsp ? second : (is_lj ? ~f : f);
    lock_d  = locked_q | bound;
    cap     = lock_d & (idx < n);
    last    = cap & (idx == n - 1'b1);
    bit_sel = IDX_W'(WORD_W - 1) - idx[IDX_W-1:0];
    word_d  = (idx == '0) ? '0 : sh_q;
    word_d[bit_sel] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q     <= '0;
      pos_q      <= POS_MAX;
      locked_q   <= 1'b0;
      got_left_q <= 1'b0;
      sh_q       <= '0;
      lbuf_q     <= '0;
      left_o     <= '0;
      right_o    <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (ev_i) begin
        hist_q   <= {hist_q[1:0], fclk_i};
        pos_q    <= pos_d;
        locked_q <= lock_d;
        if (cap) sh_q <= word_d;
        if (last && !rchan) begin
          lbuf_q     <= word_d;
          got_left_q <= 1'b1;
        end
        if (last && rchan) begin
          got_left_q <= 1'b0;
          if (got_left_q) begin
            left_o  <= lbuf_q;
            right_o <= word_d;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r7_edge_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> !ev_i);

  a_r6_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((left_o & zmask) == '0) && ((right_o & zmask) == '0)));

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              fall_edge_i,
  input  logic              dsp_late_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic [2:0] raw, syn;
  logic       ev;

  assign raw = {sdata_i, fclk_i, bclk_i};

  srx_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  srx_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (syn[0]),
    .fall_i(fall_edge_i),
    .ev_o  (ev)
  );

  srx_deser #(.WORD_W(WORD_W), .POS_W(POS_W)) i_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .fclk_i (syn[1]),
    .sd_i   (syn[2]),
    .fmt_i  (fmt_i),
    .wlen_i (wlen_i),
    .late_i (dsp_late_i),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o)
  );

endmodule

// File: tb/test_srx_top.sv
module test_srx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'd0, wlen = 2'd0;
  logic        fall = 1'b0, late = 1'b0;
  logic [31:0] left_w, right_w;
  logic        valid;

  always #5 clk = ~clk;

  srx_top i_srx_top (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .fmt_i(fmt), .wlen_i(wlen), .fall_edge_i(fall), .dsp_late_i(late),
    .left_o(left_w), .right_o(right_w), .valid_o(valid)
  );

  logic        fa [0:2047];
  logic        da [0:2047];
  logic        ga [0:2047];
  logic        ua [0:2047];
  int          seg_len;
  logic [31:0] exp_l [$];
  logic [31:0] exp_r [$];
  string       cur_req = "R10";
  int          n_chk = 0, n_bad = 0;
  logic [31:0] last_l = '0, last_r = '0;
  logic        prev_v = 1'b0;

  function automatic int nbits(input logic [1:0] c);
    case (c)
      2'd1:    return 16;
      2'd2:    return 20;
      2'd3:    return 32;
      default: return 24;
    endcase
  endfunction

  // Reference: every frame sent pushes its expected words; compared on each clock.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        n_chk++;
        if (prev_v) begin
          n_bad++;
          $display("FAIL R9 strobe wider than one cycle: valid=%0b expected=0", valid);
        end
        if (exp_l.size() == 0) begin
          n_bad++;
          $display("FAIL R9 (%s) unexpected strobe: pending=0 expected>=1", cur_req);
        end else begin
          logic [31:0] el, er;
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          n_chk += 2;
          if (left_w !== el) begin
            n_bad++;
            $display("FAIL %s left: actual=%h expected=%h", cur_req, left_w, el);
          end
          if (right_w !== er) begin
            n_bad++;
            $display("FAIL %s right: actual=%h expected=%h", cur_req, right_w, er);
          end
        end
        last_l = left_w;
        last_r = right_w;
      end else begin
        n_chk++;
        if (left_w !== last_l || right_w !== last_r) begin
          n_bad++;
          $display("FAIL R9 R8 outputs moved without strobe: actual=%h/%h expected=%h/%h",
                   left_w, right_w, last_l, last_r);
        end
      end
      prev_v = valid;
    end else begin
      last_l = '0;
      last_r = '0;
      prev_v = 1'b0;
    end
  end

  task automatic build(input int nfr, input int span, input bit idle);
    int n, off, flen, lbase, rbase, base;
    bit dsp, lj;
    logic [31:0] lw, rw;
    n    = nbits(wlen);
    dsp  = fmt[1];
    lj   = (fmt == 2'd1);
    flen = dsp ? span : 2 * span;
    off  = dsp ? (late ? 2 : 1) : (lj ? 0 : 1);
    seg_len = 2 + nfr * flen + 2;
    for (int k = 0; k < seg_len; k++) begin
      int m;
      m = (k - 2) % flen;
      da[k] = k[0] ^ k[2];
      ua[k] = 1'b0;
      ga[k] = 1'b1;
      if (k < 2)                 fa[k] = (!dsp && !lj);
      else if (k >= seg_len - 2) fa[k] = lj;
      else if (dsp)              fa[k] = (m == 0);
      else                       fa[k] = lj ? (m < span) : (m >= span);
    end
    for (int fr = 0; fr < nfr; fr++) begin
      lw = $urandom;
      rw = $urandom;
      lw = lw << (32 - n);
      rw = rw << (32 - n);
      exp_l.push_back(lw);
      exp_r.push_back(rw);
      base  = 2 + fr * flen;
      lbase = base + off;
      rbase = dsp ? base + off + n : base + span + off;
      for (int i = 0; i < n; i++) begin
        da[lbase+i] = lw[31-i]; ua[lbase+i] = 1'b1;
        da[rbase+i] = rw[31-i]; ua[rbase+i] = 1'b1;
      end
    end
    if (idle) begin
      for (int k = 2; k < seg_len - 2; k++) begin
        int j;
        j = dsp ? (k - 2) % flen : ((k - 2) % flen) % span;
        if (!ua[k] && j >= 2) ga[k] = 1'b0;
      end
    end
  endtask

  task automatic play();
    for (int k = 0; k < seg_len; k++) begin
      @(negedge clk);
      bclk  = fall;
      fclk  = fa[k];
      sdata = da[k];
      repeat (4) @(negedge clk);
      if (ga[k]) bclk = ~fall;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    bclk = fall;
  endtask

  task automatic run_seg(input string req, input logic [1:0] f_c, input logic [1:0] w_c,
                         input logic fe, input logic lt, input int nfr, input int span,
                         input bit idle);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f_c; wlen = w_c; fall = fe; late = lt;
    bclk = fe; fclk = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = req;
    build(nfr, span, idle);
    play();
    repeat (30) @(negedge clk);
    n_chk++;
    if (exp_l.size() != 0) begin
      n_bad++;
      $display("FAIL R9 (%s) frames never strobed: pending=%0d expected=0", req, exp_l.size());
    end
    exp_l.delete();
    exp_r.delete();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: run incomplete after 150000 cycles, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (left_w !== '0 || right_w !== '0 || valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: actual=%h/%h/%b expected=0/0/0", left_w, right_w, valid);
    end
    run_seg("R1 R5 R6",    2'd0, 2'd0, 1'b0, 1'b0, 3, 32, 1'b0);
    run_seg("R1 R5",       2'd0, 2'd3, 1'b0, 1'b0, 3, 32, 1'b0);
    run_seg("R2 R5 R6 R8", 2'd1, 2'd1, 1'b0, 1'b0, 3, 32, 1'b0);
    run_seg("R2 R5 R6",    2'd1, 2'd2, 1'b0, 1'b0, 3, 24, 1'b0);
    run_seg("R3 R6",       2'd2, 2'd0, 1'b0, 1'b0, 3, 50, 1'b0);
    run_seg("R4 R6",       2'd2, 2'd1, 1'b0, 1'b1, 3, 34, 1'b0);
    run_seg("R7 R1",       2'd0, 2'd0, 1'b1, 1'b0, 3, 32, 1'b0);
    run_seg("R7 R4",       2'd2, 2'd3, 1'b1, 1'b1, 2, 66, 1'b0);
    run_seg("R8 R2",       2'd1, 2'd1, 1'b0, 1'b0, 3, 32, 1'b1);
    run_seg("R8 R1",       2'd0, 2'd0, 1'b0, 1'b0, 3, 32, 1'b1);
    run_seg("R8 R4",       2'd2, 2'd1, 1'b0, 1'b1, 3, 40, 1'b1);
    finish_run();
  end

endmodule